// File: doc/BRIEF.md
# Clock Select Capture and Output Gate Control

This block is the control side of a clock generator. It decides which five-bit frequency-select code drives the synthesizer. It also decides, for each clock output, whether the output runs, is held low, or is put into high impedance. The select code comes from one of two places. The first is a set of board strap pins, captured while an active-low strobe is asserted. The second is a select field written by software. A single override bit chooses between the two.

Single-ended outputs come in two groups. The first group can be stopped by software. The second is a reference group that can only be enabled. Each output in the stoppable group has its own enable bit and its own opt-in bit. When an output has opted in, a software stop request holds it low. A gate only changes on a control-clock edge at which that output's source clock is low, so gating never cuts a pulse short. Differential outputs are never stopped. Their enables drive output-enable signals directly, and a cleared enable puts the pair in high impedance. A spread-spectrum enable bit is passed through to the synthesizer.

Top module: `clk_fsel_gate`

## Requirements
- R1: On every rising `clk` edge at which `strobe_n` is 0, `latched_sel` takes the value of `strap`, visible after that edge.
- R2: On a rising `clk` edge at which `strobe_n` is 1, `latched_sel` keeps its value, whatever `strap` does.
- R3: While `ovr_sel` is 0, `act_sel` equals `latched_sel`.
- R4: While `ovr_sel` is 1, `act_sel` equals `sw_sel`.
- R5: A stoppable-group output whose `pcif_en` bit is 0 has its gate cleared at the next edge where its source clock is low.
- R6: A stoppable-group output that is enabled and has its `pcif_stop_ok` bit at 0 has its gate set at such an edge, whatever the value of `stop_req`.
- R7: A stoppable-group output that is enabled and has its `pcif_stop_ok` bit at 1 has its gate cleared at such an edge while `stop_req` is 1, and set while `stop_req` is 0.
- R8: A gate bit only changes on an edge where its source clock input is 1'b0. Each gated output equals its source clock ANDed with its gate, so it is held low while the gate is 0.
- R9: `cpu_oe` follows `cpu_en` bit for bit, combinationally. A 0 bit means that differential pair is in high impedance.
- R10: Each reference output gate follows its `ref_en` bit, under the same low-phase update rule. `stop_req` has no effect on it.
- R11: `ssc_on` follows `ssc_en`.
- R12: While `rst_n` is 0, `latched_sel` and every gate bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Active-low strap capture strobe |
| strap | input | SEL_W | Strap select inputs |
| ovr_sel | input | 1 | 1 selects the software field, 0 selects the latched straps |
| sw_sel | input | SEL_W | Software select field |
| stop_req | input | 1 | Software stop request |
| pcif_en | input | N_PCIF | Enable bits for the stoppable group |
| pcif_stop_ok | input | N_PCIF | Per-output opt-in to the stop request |
| pcif_src | input | N_PCIF | Ungated source clocks of the stoppable group |
| ref_en | input | N_REF | Enable bits for the reference group |
| ref_src | input | N_REF | Ungated reference source clocks |
| cpu_en | input | N_CPU | Differential pair enable bits |
| ssc_en | input | 1 | Spread-spectrum enable bit |
| act_sel | output | SEL_W | Active frequency-select code |
| latched_sel | output | SEL_W | Captured strap value, read-only |
| pcif_gate | output | N_PCIF | Gate state of the stoppable group |
| pcif_out | output | N_PCIF | Gated stoppable-group clocks |
| ref_gate | output | N_REF | Gate state of the reference group |
| ref_out | output | N_REF | Gated reference clocks |
| cpu_oe | output | N_CPU | Output enable per differential pair |
| ssc_on | output | 1 | Spread-spectrum control to the synthesizer |

## Verification
Two pairs of events can fall in the same cycle. In the first, a strap capture and a flip of the override bit occur together. The stimulus lowers `strobe_n` with new straps while `ovr_sel` toggles. The check requires `act_sel` to show the software field in that cycle and the new straps once the override falls. In the second, a change in the stop request meets a source clock that is high. Random source-clock levels are applied together with stop-request toggles, and a bench model confirms that the gate waits for the next low-phase edge and that the output is never high while the gate is 0.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  // Gate wanted for one single-ended output.
  function automatic logic gate_want(input logic en, input logic stop_ok, input logic stop);
    return en & ~(stop_ok & stop);
  endfunction

  // Active select code.
  function automatic logic [7:0] pick_sel(input logic ovr, input logic [7:0] strap_v,
                                          input logic [7:0] sw_v);
    return ovr ? sw_v : strap_v;
  endfunction
endpackage

// File: rtl/fsel_latch.sv
module fsel_latch #(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_n,
  input  logic [SEL_W-1:0] strap,
  output logic [SEL_W-1:0] latched
);
  logic capture;
  assign capture = ~strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latched <= '0;
    else if (capture) latched <= strap;
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> latched == $past(strap));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |=> $stable(latched));
endmodule

// File: rtl/se_gate_bank.sv
module se_gate_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en,
  input  logic [N-1:0] stop_ok,
  input  logic         stop_req,
  input  logic [N-1:0] src,
  output logic [N-1:0] gate,
  output logic [N-1:0] clk_out
);
  import fsg_pkg::*;

  logic [N-1:0] want;
  logic [N-1:0] low_phase;

  for (genvar i = 0; i < N; i++) begin : g_out
    assign want[i]      = gate_want(en[i], stop_ok[i], stop_req);
    assign low_phase[i] = ~src[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            gate[i] <= 1'b0;
      else if (low_phase[i]) gate[i] <= want[i];
    end

    assign clk_out[i] = src[i] & gate[i];

    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      src[i] |=> $stable(gate[i]));
    assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (low_phase[i] && !en[i]) |=> !gate[i]);
    assert_free_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (low_phase[i] && en[i] && !stop_ok[i]) |=> gate[i]);
    assert_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (low_phase[i] && en[i] && stop_ok[i] && stop_req) |=> !gate[i]);
  end
endmodule

// File: rtl/clk_fsel_gate.sv
module clk_fsel_gate #(
  parameter int SEL_W  = 5,
  parameter int N_PCIF = 3,
  parameter int N_REF  = 2,
  parameter int N_CPU  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic [SEL_W-1:0]  strap,
  input  logic              ovr_sel,
  input  logic [SEL_W-1:0]  sw_sel,
  input  logic              stop_req,
  input  logic [N_PCIF-1:0] pcif_en,
  input  logic [N_PCIF-1:0] pcif_stop_ok,
  input  logic [N_PCIF-1:0] pcif_src,
  input  logic [N_REF-1:0]  ref_en,
  input  logic [N_REF-1:0]  ref_src,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic              ssc_en,
  output logic [SEL_W-1:0]  act_sel,
  output logic [SEL_W-1:0]  latched_sel,
  output logic [N_PCIF-1:0] pcif_gate,
  output logic [N_PCIF-1:0] pcif_out,
  output logic [N_REF-1:0]  ref_gate,
  output logic [N_REF-1:0]  ref_out,
  output logic [N_CPU-1:0]  cpu_oe,
  output logic              ssc_on
);
  import fsg_pkg::*;

  localparam int PADW = 8 - SEL_W;

  logic [7:0] sel_wide;

  fsel_latch #(.SEL_W(SEL_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .strap(strap), .latched(latched_sel)
  );

  assign sel_wide = pick_sel(ovr_sel, {{PADW{1'b0}}, latched_sel}, {{PADW{1'b0}}, sw_sel});
  assign act_sel  = sel_wide[SEL_W-1:0];

  se_gate_bank #(.N(N_PCIF)) u_pcif (
    .clk(clk), .rst_n(rst_n), .en(pcif_en), .stop_ok(pcif_stop_ok), .stop_req(stop_req),
    .src(pcif_src), .gate(pcif_gate), .clk_out(pcif_out)
  );

  se_gate_bank #(.N(N_REF)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(ref_en), .stop_ok({N_REF{1'b0}}), .stop_req(stop_req),
    .src(ref_src), .gate(ref_gate), .clk_out(ref_out)
  );

  assign cpu_oe = cpu_en;
  assign ssc_on = ssc_en;

  assert_ref_ignores_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en[0] && !ref_src[0]) |=> ref_gate[0]);
endmodule

// File: tb/tb_clk_fsel_gate.sv
module tb_clk_fsel_gate;
  localparam int SEL_W = 5, NP = 3, NR = 2, NC = 2;

  logic clk = 1'b0, rst_n = 1'b0, strobe_n, ovr_sel, stop_req, ssc_en;
  logic [SEL_W-1:0] strap, sw_sel, act_sel, latched_sel;
  logic [NP-1:0] pcif_en, pcif_stop_ok, pcif_src, pcif_gate, pcif_out;
  logic [NR-1:0] ref_en, ref_src, ref_gate, ref_out;
  logic [NC-1:0] cpu_en, cpu_oe;
  logic ssc_on;

  int checks = 0, errors = 0;
  logic [SEL_W-1:0] m_lat = '0;
  logic [NP-1:0] m_pg = '0;
  logic [NR-1:0] m_rg = '0;

  always #4 clk = ~clk;

  clk_fsel_gate #(.SEL_W(SEL_W), .N_PCIF(NP), .N_REF(NR), .N_CPU(NC)) dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .strap(strap), .ovr_sel(ovr_sel),
    .sw_sel(sw_sel), .stop_req(stop_req), .pcif_en(pcif_en), .pcif_stop_ok(pcif_stop_ok),
    .pcif_src(pcif_src), .ref_en(ref_en), .ref_src(ref_src), .cpu_en(cpu_en),
    .ssc_en(ssc_en), .act_sel(act_sel), .latched_sel(latched_sel), .pcif_gate(pcif_gate),
    .pcif_out(pcif_out), .ref_gate(ref_gate), .ref_out(ref_out), .cpu_oe(cpu_oe),
    .ssc_on(ssc_on)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic want(input logic en, input logic ok, input logic stp);
    if (!en) return 1'b0;
    if (ok && stp) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_edge();
    if (!strobe_n) m_lat = strap;
    for (int i = 0; i < NP; i++)
      if (pcif_src[i] == 1'b0) m_pg[i] = want(pcif_en[i], pcif_stop_ok[i], stop_req);
    for (int i = 0; i < NR; i++)
      if (ref_src[i] == 1'b0) m_rg[i] = ref_en[i];
  endtask

  task automatic check_all(input logic last_strobe_n);
    chk(last_strobe_n ? "R2" : "R1", latched_sel, m_lat);
    chk(ovr_sel ? "R4" : "R3", act_sel, ovr_sel ? sw_sel : m_lat);
    for (int i = 0; i < NP; i++) begin
      if (!pcif_en[i])                       chk("R5", pcif_gate[i], m_pg[i]);
      else if (pcif_stop_ok[i] && stop_req)  chk("R7", pcif_gate[i], m_pg[i]);
      else                                   chk("R6", pcif_gate[i], m_pg[i]);
    end
    chk("R8", pcif_out, pcif_src & m_pg);
    chk("R10", ref_gate, m_rg);
    chk("R8", ref_out, ref_src & m_rg);
    chk("R9", cpu_oe, cpu_en);
    chk("R11", ssc_on, ssc_en);
  endtask

  initial begin : wdog
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic last_sn;
    void'($urandom(32'd1234));
    strobe_n = 1'b1; strap = 5'h1f; ovr_sel = 1'b0; sw_sel = '0; stop_req = 1'b0;
    pcif_en = '1; pcif_stop_ok = '0; pcif_src = '0; ref_en = '1; ref_src = '0;
    cpu_en = '0; ssc_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", latched_sel, 0);
    chk("R12", pcif_gate, 0);
    chk("R12", ref_gate, 0);
    rst_n = 1'b1;
    last_sn = 1'b1;
    for (int it = 0; it < 600; it++) begin
      if (it < 2) begin
        strobe_n = 1'b0; strap = 5'h15; ovr_sel = 1'b1; sw_sel = 5'h0a;
        stop_req = 1'b1; pcif_stop_ok = 3'b101; pcif_src = '0;
      end else if (it < 4) begin
        strobe_n = 1'b1; strap = 5'h03; ovr_sel = 1'b0;
        stop_req = 1'b0; pcif_src = 3'b111;
      end else begin
        strobe_n = ($urandom % 4) == 0;
        strobe_n = ~strobe_n;
        strap = SEL_W'($urandom);
        ovr_sel = $urandom % 2;
        sw_sel = SEL_W'($urandom);
        stop_req = $urandom % 2;
        pcif_en = NP'($urandom | $urandom);
        pcif_stop_ok = NP'($urandom);
        pcif_src = NP'($urandom);
        ref_en = NR'($urandom);
        ref_src = NR'($urandom);
        cpu_en = NC'($urandom);
        ssc_en = $urandom % 2;
      end
      #1;
      chk(ovr_sel ? "R4" : "R3", act_sel, ovr_sel ? sw_sel : m_lat);
      @(posedge clk);
      model_edge();
      last_sn = strobe_n;
      @(negedge clk);
      check_all(last_sn);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule